// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is the control path of a pipelined synchronous burst SRAM, together with a behavioral storage array. On every rising clock edge it looks at three chip enables, two address strobes, an advance input and the write enables. From these it picks one of four cycle kinds: deselect, begin burst, continue burst or suspend burst. The processor-side strobe has priority and always starts a read. The controller-side strobe can start either a read or a write. With both strobes high, the advance input moves the burst to the next address or holds it at the current one. The burst address is a 2-bit counter on the low address bits. It wraps inside a 4-word group in linear order.

Reads are pipelined. The address is registered on one edge and the word is registered onto the data output on the next edge. The data output is meant for an external tri-state pad, so it is given as a value and a drive enable. The drive enable follows the active-low output enable with no clock. It is masked for the interval after a write cycle and whenever the device is asleep or waking up. A sleep input powers the device down within two edges. After sleep is released, two more edges pass before a command is accepted again.

The control state machine has five states. ST_IDLE means no burst is live. ST_BURST means a burst is live. ST_DOZE is the committed sleep entry. ST_SLEEP is powered down. ST_WAKE is recovery. The transitions are as follows:
- From ST_IDLE to ST_BURST on an accepted begin cycle.
- From ST_BURST back to ST_IDLE on a deselect.
- From ST_IDLE or ST_BURST to ST_DOZE when sleep is sampled high.
- From ST_DOZE to ST_SLEEP unconditionally.
- From ST_SLEEP to ST_WAKE when sleep is sampled low.
- From ST_WAKE to ST_IDLE unconditionally.

Top module: `burst_sram_core`

## Requirements
- R1: After reset the state is ST_IDLE and data_oe is low even with out_en_n low. Continue and suspend cycles in ST_IDLE perform no access.
- R2: With sel_a_n low and strobe_cpu_n low, the cycle is one of two kinds. If selected (sel_a_n low, sel_b high, sel_c_n low), it is a begin-burst read from addr, whatever the write enables are, and no memory lane is written. Otherwise it is a deselect.
- R3: With the processor strobe not in effect and strobe_ctl_n low while selected, the cycle begins a burst at addr. It is a write when the combined write is active and a read otherwise.
- R4: The combined write is active when all_wr_n is low, or when lane_wr_en_n is low and at least one lane_sel_n bit is low. All_wr_n low writes all four 8-bit lanes. Otherwise lane i (data bits 8i+7..8i) is written only when lane_sel_n[i] is low, and the other lanes keep their contents.
- R5: A deselect has two forms. The first is sel_a_n high with strobe_ctl_n low. The second is sel_a_n low with sel_b low or sel_c_n high while either strobe is low. A deselect writes nothing, ends the burst (state goes to ST_IDLE) and clears data_oe from the second interval after it.
- R6: While sel_a_n is high, strobe_cpu_n has no effect. The cycle is decoded from strobe_ctl_n and step_n alone.
- R7: With both strobes high and step_n low during a live burst, the access uses the next address. The low two address bits increment modulo 4 and the upper bits are kept. The chip enables are ignored, and the combined write selects read or write.
- R8: With both strobes high and step_n high during a live burst, the access repeats the current address, as a read or a write set by the combined write.
- R9: A read whose address is registered on edge k drives the word on data_out with data_oe high in the interval after edge k+1. The word reflects all writes registered on edges before k+1.
- R10: data_oe responds to out_en_n without a clock edge. It is forced low in the interval after a write cycle.
- R11: Sleep_req sampled high in ST_IDLE or ST_BURST moves the state to ST_DOZE and then to ST_SLEEP. From that edge data_oe is low and no command is accepted.
- R12: Sleep_req sampled low in ST_SLEEP on edge e leads through ST_WAKE to ST_IDLE. Commands on edges e and e+1 are ignored, and a command on edge e+2 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Power-down request, active high |
| sel_a_n | input | 1 | Primary chip enable, active low |
| sel_b | input | 1 | Second chip enable, active high |
| sel_c_n | input | 1 | Third chip enable, active low |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst advance, low = next address, high = hold |
| all_wr_n | input | 1 | Global write, active low, writes every lane |
| lane_wr_en_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Per-lane byte enables, active low |
| addr | input | ADDR_W | External word address |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| data_in | input | LANES*LANE_W | Write data from the pad |
| data_out | output | LANES*LANE_W | Read data to the pad |
| data_oe | output | 1 | Pad drive enable, high = drive data_out |

## Verification
The bench first writes a known pattern through controller-strobe bursts. It then goes after the cases that a wrong design would show at the pins. A processor-strobe cycle with the global write held low must not corrupt memory. A wrong priority would show up as a changed word on readback. A continue from the top word of a 4-word group must wrap to the bottom; a carry into the upper bits would return a word from the next group. Two more cases test the gating conditions. A deselected write attempt must leave the word unchanged, and a processor strobe with the primary enable high must act as a continue. A wrong decode in either case gives stale or misplaced data. Other cases test sleep and the output enable: commands arriving in the two recovery edges after sleep must be dropped, drive must stop at once on sleep entry, and the output enable must gate drive mid-cycle. These mix with seeded random cycles that a reference model scores edge by edge.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    typedef enum logic [1:0] {
        CYC_DESEL,
        CYC_BEGIN,
        CYC_CONT,
        CYC_SUSP
    } cyc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BURST,
        ST_DOZE,
        ST_SLEEP,
        ST_WAKE
    } st_e;

    typedef struct packed {
        cyc_e kind;
        logic wr;
    } cmd_t;

endpackage

// File: rtl/bsram_decode.sv
module bsram_decode
    import bsram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             strobe_cpu_n,
    input  logic             strobe_ctl_n,
    input  logic             step_n,
    input  logic             all_wr_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    output cmd_t             cmd,
    output logic [LANES-1:0] lanes
);

    logic             selected;
    logic             wr_any;
    logic [LANES-1:0] mask;

    always_comb begin
        selected = !sel_a_n && sel_b && !sel_c_n;
        wr_any   = !all_wr_n || (!lane_wr_en_n && (lane_sel_n != '1));
        if (!all_wr_n) begin
            mask = '1;
        end else if (!lane_wr_en_n) begin
            mask = ~lane_sel_n;
        end else begin
            mask = '0;
        end
    end

    always_comb begin
        if (!sel_a_n && !strobe_cpu_n) begin
            cmd.kind = selected ? CYC_BEGIN : CYC_DESEL;
            cmd.wr   = 1'b0;
        end else if (!strobe_ctl_n) begin
            cmd.kind = selected ? CYC_BEGIN : CYC_DESEL;
            cmd.wr   = selected && wr_any;
        end else begin
            cmd.kind = step_n ? CYC_SUSP : CYC_CONT;
            cmd.wr   = wr_any;
        end
        lanes = cmd.wr ? mask : '0;
    end

    always_comb begin
        // R2
        cpu_read_chk: assert (sel_a_n || strobe_cpu_n || !cmd.wr);
        // R4
        global_lanes_chk: assert (all_wr_n || !cmd.wr || (lanes == '1));
    end

endmodule

// File: rtl/bsram_addr.sv
module bsram_addr #(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    input  logic              adv,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] cur_addr
);

    logic [CNT_W-1:0] next_low;

    always_comb begin
        next_low = cur_addr[CNT_W-1:0] + 1'b1;
        if (load) begin
            eff_addr = ext_addr;
        end else if (adv) begin
            eff_addr = {cur_addr[ADDR_W-1:CNT_W], next_low};
        end else begin
            eff_addr = cur_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else if (en) begin
            cur_addr <= eff_addr;
        end
    end

    // R7
    cont_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && adv) |=>
            ((cur_addr[CNT_W-1:0] == CNT_W'($past(cur_addr[CNT_W-1:0]) + 1'b1)) &&
             (cur_addr[ADDR_W-1:CNT_W] == $past(cur_addr[ADDR_W-1:CNT_W]))));

    // R8
    susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && !adv) |=> $stable(cur_addr));

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         wr_lanes,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [LANES*LANE_W-1:0]  wr_data,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [LANES*LANE_W-1:0]  q,
    output logic                     q_valid
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        logic [LANE_W-1:0] q_lane;

        always_ff @(posedge clk) begin
            if (wr_lanes[g]) begin
                cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
            if (rd_en) begin
                q_lane <= cells[rd_addr];
            end
        end

        assign q[g*LANE_W +: LANE_W] = q_lane;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
        end else begin
            q_valid <= rd_en;
        end
    end

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int CNT_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep_req,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    strobe_cpu_n,
    input  logic                    strobe_ctl_n,
    input  logic                    step_n,
    input  logic                    all_wr_n,
    input  logic                    lane_wr_en_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    out_en_n,
    input  logic [LANES*LANE_W-1:0] data_in,
    output logic [LANES*LANE_W-1:0] data_out,
    output logic                    data_oe
);

    localparam int DATA_W = LANES * LANE_W;

    cmd_t              cmd;
    logic [LANES-1:0]  dec_lanes;
    logic [LANES-1:0]  wr_lanes;
    st_e               st;
    st_e               st_nx;
    logic              awake;
    logic              accepted;
    logic              do_begin;
    logic              do_step;
    logic              do_adv;
    logic              do_op;
    logic              do_wr;
    logic              do_rd;
    logic              pipe_rd;
    logic              last_wr;
    logic              q_valid;
    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] q;

    bsram_decode #(.LANES(LANES)) u_decode (
        .sel_a_n      (sel_a_n),
        .sel_b        (sel_b),
        .sel_c_n      (sel_c_n),
        .strobe_cpu_n (strobe_cpu_n),
        .strobe_ctl_n (strobe_ctl_n),
        .step_n       (step_n),
        .all_wr_n     (all_wr_n),
        .lane_wr_en_n (lane_wr_en_n),
        .lane_sel_n   (lane_sel_n),
        .cmd          (cmd),
        .lanes        (dec_lanes)
    );

    // Output process: what the current edge does, and the pad enable.
    always_comb begin
        awake    = (st == ST_IDLE) || (st == ST_BURST);
        accepted = awake && !sleep_req;
        do_begin = accepted && (cmd.kind == CYC_BEGIN);
        do_step  = accepted && (st == ST_BURST) &&
                   ((cmd.kind == CYC_CONT) || (cmd.kind == CYC_SUSP));
        do_adv   = do_step && (cmd.kind == CYC_CONT);
        do_op    = do_begin || do_step;
        do_wr    = do_op && cmd.wr;
        do_rd    = do_op && !cmd.wr;
        wr_lanes = do_wr ? dec_lanes : '0;
        data_oe  = q_valid && !last_wr && !out_en_n && awake;
        data_out = q;
    end

    // Next-state process.
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (sleep_req) begin
                    st_nx = ST_DOZE;
                end else if (cmd.kind == CYC_BEGIN) begin
                    st_nx = ST_BURST;
                end
            end
            ST_BURST: begin
                if (sleep_req) begin
                    st_nx = ST_DOZE;
                end else if (cmd.kind == CYC_DESEL) begin
                    st_nx = ST_IDLE;
                end
            end
            ST_DOZE:  st_nx = ST_SLEEP;
            ST_SLEEP: begin
                if (!sleep_req) begin
                    st_nx = ST_WAKE;
                end
            end
            ST_WAKE:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_rd <= 1'b0;
            last_wr <= 1'b0;
        end else begin
            pipe_rd <= do_rd;
            last_wr <= do_wr;
        end
    end

    bsram_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (do_op),
        .load     (do_begin),
        .adv      (do_adv),
        .ext_addr (addr),
        .eff_addr (eff_addr),
        .cur_addr (cur_addr)
    );

    bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lanes (wr_lanes),
        .wr_addr  (eff_addr),
        .wr_data  (data_in),
        .rd_en    (pipe_rd),
        .rd_addr  (cur_addr),
        .q        (q),
        .q_valid  (q_valid)
    );

    // R9
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_valid) |-> $past(do_rd, 2));

    // R11
    doze_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DOZE) |=> (st == ST_SLEEP));

    // R11
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLEEP) |-> (!q_valid && !pipe_rd));

    // R12
    wake_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAKE) |=> ((st == ST_IDLE) && !$past(pipe_rd) && !$past(last_wr)));

    // R5
    desel_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && (cmd.kind == CYC_DESEL)) |=> ((st == ST_IDLE) && !last_wr));

endmodule

// File: tb/test_burst_sram_core.sv
module test_burst_sram_core;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int LN    = 4;
    localparam int LW    = 8;
    localparam int DW    = LN * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_req = 1'b0;
    logic          sel_a_n = 1'b1;
    logic          sel_b = 1'b0;
    logic          sel_c_n = 1'b1;
    logic          strobe_cpu_n = 1'b1;
    logic          strobe_ctl_n = 1'b1;
    logic          step_n = 1'b1;
    logic          all_wr_n = 1'b1;
    logic          lane_wr_en_n = 1'b1;
    logic [LN-1:0] lane_sel_n = '1;
    logic [AW-1:0] addr = '0;
    logic          out_en_n = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic [DW-1:0] data_out;
    logic          data_oe;

    burst_sram_core #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .CNT_W(2)) i_burst_sram_core (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .step_n(step_n),
        .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
        .addr(addr), .out_en_n(out_en_n), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: 0 idle, 1 burst, 2 doze, 3 sleep, 4 wake
    int            m_st = 0;
    logic [AW-1:0] m_cur = '0;
    logic          m_pipe = 1'b0;
    logic          m_qv = 1'b0;
    logic          m_lw = 1'b0;
    logic [DW-1:0] m_q = '0;
    logic [DW-1:0] m_mem [DEPTH];

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    finished = 1'b0;

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'(32'h5A00_0000 ^ (a * 32'h0001_0203) ^ (salt * 32'h0100_0001));
    endfunction

    task automatic model_edge();
        logic          aw, acc, selected, wr_any, wr, beg, stp, op, dwr, drd, qv_n;
        logic [LN-1:0] mask;
        logic [AW-1:0] eff;
        int            kind;
        if (!rst_n) begin
            m_st = 0; m_cur = '0; m_pipe = 1'b0; m_qv = 1'b0; m_lw = 1'b0;
            return;
        end
        aw       = (m_st == 0) || (m_st == 1);
        acc      = aw && !sleep_req;
        selected = !sel_a_n && sel_b && !sel_c_n;
        wr_any   = !all_wr_n || (!lane_wr_en_n && (lane_sel_n != '1));
        mask     = !all_wr_n ? '1 : (!lane_wr_en_n ? ~lane_sel_n : '0);
        if (!sel_a_n && !strobe_cpu_n) begin
            kind = selected ? 1 : 0; wr = 1'b0;
        end else if (!strobe_ctl_n) begin
            kind = selected ? 1 : 0; wr = selected && wr_any;
        end else begin
            kind = step_n ? 3 : 2; wr = wr_any;
        end
        beg = acc && (kind == 1);
        stp = acc && (m_st == 1) && (kind >= 2);
        op  = beg || stp;
        dwr = op && wr;
        drd = op && !wr;
        if (beg) eff = addr;
        else if (kind == 2) eff = {m_cur[AW-1:2], m_cur[1:0] + 2'd1};
        else eff = m_cur;
        qv_n = m_pipe;
        if (m_pipe) m_q = m_mem[m_cur];
        if (dwr) begin
            for (int l = 0; l < LN; l++) begin
                if (mask[l]) m_mem[eff][l*LW +: LW] = data_in[l*LW +: LW];
            end
        end
        case (m_st)
            0: if (sleep_req) m_st = 2; else if (kind == 1) m_st = 1;
            1: if (sleep_req) m_st = 2; else if (kind == 0) m_st = 0;
            2: m_st = 3;
            3: if (!sleep_req) m_st = 4;
            default: m_st = 0;
        endcase
        m_pipe = drd;
        m_lw   = dwr;
        if (op) m_cur = eff;
        m_qv = qv_n;
    endtask

    task automatic check_outputs();
        logic exp_oe;
        exp_oe = m_qv && !m_lw && !out_en_n && ((m_st == 0) || (m_st == 1));
        checks++;
        if (data_oe !== exp_oe) begin
            errors++;
            $display("FAIL %s data_oe actual %0b expected %0b at %0t", tag, data_oe, exp_oe, $time);
        end
        if (exp_oe) begin
            checks++;
            if (data_out !== m_q) begin
                errors++;
                $display("FAIL %s data_out actual %h expected %h at %0t", tag, data_out, m_q, $time);
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_outputs();
    endtask

    task automatic set_sel(input logic ok);
        sel_a_n = 1'b0; sel_b = ok; sel_c_n = 1'b0;
    endtask

    task automatic no_write();
        all_wr_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = '1;
    endtask

    task automatic op_begin_wr(input int a, input logic [DW-1:0] d);
        set_sel(1'b1); strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b0; step_n = 1'b1;
        no_write(); all_wr_n = 1'b0; addr = AW'(a); data_in = d; out_en_n = 1'b1;
        tick();
    endtask

    task automatic op_begin_rd_cpu(input int a);
        set_sel(1'b1); strobe_cpu_n = 1'b0; strobe_ctl_n = 1'b1; step_n = 1'b1;
        all_wr_n = 1'b0; lane_wr_en_n = 1'b0; lane_sel_n = '0;
        addr = AW'(a); data_in = '1; out_en_n = 1'b0;
        tick();
    endtask

    task automatic op_burst(input logic adv, input logic wr, input logic [DW-1:0] d);
        sel_a_n = 1'b1; sel_b = 1'b0; sel_c_n = 1'b1;
        strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; step_n = !adv;
        no_write(); all_wr_n = !wr; data_in = d; out_en_n = wr;
        tick();
    endtask

    task automatic op_desel();
        sel_a_n = 1'b1; strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b0;
        no_write(); out_en_n = 1'b0;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;

        // R1: reset state, burst cycles do nothing while idle
        tag = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        out_en_n = 1'b0;
        tick();
        op_burst(1'b1, 1'b0, '0);
        op_burst(1'b0, 1'b0, '0);
        op_burst(1'b1, 1'b0, '0);

        // R3 / R7: fill every word through controller-strobe write bursts
        tag = "R3";
        for (int b = 0; b < DEPTH; b += 4) begin
            op_begin_wr(b + 2, pat(b + 2, 0));
            tag = "R7";
            op_burst(1'b1, 1'b1, pat(b + 3, 0));
            op_burst(1'b1, 1'b1, pat(b, 0));
            op_burst(1'b1, 1'b1, pat(b + 1, 0));
            tag = "R3";
        end
        op_desel();

        // R2: processor-strobe reads with write enables low, wrap in group
        tag = "R2";
        for (int b = 0; b < DEPTH; b += 4) begin
            op_begin_rd_cpu(b + 3);
            tag = "R7";
            op_burst(1'b1, 1'b0, '0);
            op_burst(1'b1, 1'b0, '0);
            op_burst(1'b1, 1'b0, '0);
            tag = "R2";
        end
        op_burst(1'b1, 1'b0, '0);
        op_desel();
        op_desel();

        // R4: byte-lane writes, and byte enables without lane_wr_en_n
        tag = "R4";
        set_sel(1'b1); strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b0; step_n = 1'b1;
        all_wr_n = 1'b1; lane_wr_en_n = 1'b0; lane_sel_n = 4'b1010;
        addr = AW'(9); data_in = 32'hC3C3_C3C3; out_en_n = 1'b1;
        tick();
        lane_wr_en_n = 1'b1; lane_sel_n = 4'b0000; addr = AW'(10);
        data_in = 32'h1111_1111; out_en_n = 1'b0;
        tick();
        op_burst(1'b0, 1'b0, '0);
        op_begin_rd_cpu(9);
        op_burst(1'b0, 1'b0, '0);
        op_burst(1'b0, 1'b0, '0);

        // R10: output enable without a clock, masked after a write
        tag = "R10";
        out_en_n = 1'b1; #1 check_outputs();
        out_en_n = 1'b0; #1 check_outputs();
        op_burst(1'b0, 1'b1, 32'h7777_0000);
        op_burst(1'b0, 1'b0, '0);
        op_burst(1'b0, 1'b0, '0);

        // R5: deselect forms; a deselected write attempt changes nothing
        tag = "R5";
        op_desel();
        op_burst(1'b1, 1'b0, '0);
        op_burst(1'b0, 1'b0, '0);
        set_sel(1'b0); strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b0;
        all_wr_n = 1'b0; addr = AW'(5); data_in = 32'hDEAD_BEEF; out_en_n = 1'b1;
        tick();
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b1; strobe_cpu_n = 1'b0;
        addr = AW'(6); tick();
        op_begin_rd_cpu(5);
        op_burst(1'b1, 1'b0, '0);
        op_burst(1'b1, 1'b0, '0);

        // R6: processor strobe ignored with sel_a_n high
        tag = "R6";
        op_begin_rd_cpu(8);
        sel_a_n = 1'b1; sel_b = 1'b1; sel_c_n = 1'b0;
        strobe_cpu_n = 1'b0; strobe_ctl_n = 1'b1; step_n = 1'b0;
        no_write(); addr = AW'(40); out_en_n = 1'b0;
        tick();
        op_burst(1'b0, 1'b0, '0);
        op_burst(1'b0, 1'b0, '0);

        // R8: suspend repeats current address, also as a write
        tag = "R8";
        op_begin_rd_cpu(13);
        op_burst(1'b0, 1'b0, '0);
        op_burst(1'b0, 1'b1, 32'h0BAD_F00D);
        op_burst(1'b0, 1'b0, '0);
        op_burst(1'b0, 1'b0, '0);
        op_burst(1'b0, 1'b0, '0);

        // R9: back-to-back begin reads at distinct addresses
        tag = "R9";
        op_begin_rd_cpu(20);
        op_begin_rd_cpu(33);
        op_begin_rd_cpu(47);
        op_burst(1'b0, 1'b0, '0);

        // R11: sleep during a live read burst
        tag = "R11";
        op_begin_rd_cpu(24);
        op_burst(1'b1, 1'b0, '0);
        sleep_req = 1'b1;
        op_burst(1'b1, 1'b0, '0);
        op_burst(1'b1, 1'b1, 32'hAAAA_5555);
        op_begin_wr(30, 32'h3030_3030);
        op_burst(1'b1, 1'b0, '0);

        // R12: commands on the two recovery edges are dropped
        tag = "R12";
        sleep_req = 1'b0;
        op_begin_wr(41, 32'h4141_4141);
        op_begin_wr(42, 32'h4242_4242);
        op_begin_wr(43, 32'h4343_4343);
        op_begin_rd_cpu(41);
        op_begin_rd_cpu(42);
        op_begin_rd_cpu(43);
        op_begin_rd_cpu(30);
        op_burst(1'b0, 1'b0, '0);
        op_burst(1'b0, 1'b0, '0);

        // Seeded random cycles scored against the model
        tag = "R9";
        begin
            int sleep_left = 0;
            for (int n = 0; n < 3000; n++) begin
                sel_a_n      = ($urandom % 8) == 0;
                sel_b        = ($urandom % 8) != 0;
                sel_c_n      = ($urandom % 8) == 0;
                strobe_cpu_n = ($urandom % 4) != 0;
                strobe_ctl_n = ($urandom % 4) != 0;
                step_n       = ($urandom % 3) == 0;
                all_wr_n     = ($urandom % 3) != 0;
                lane_wr_en_n = ($urandom % 2) != 0;
                lane_sel_n   = LN'($urandom);
                addr         = AW'($urandom);
                data_in      = DW'($urandom);
                out_en_n     = ($urandom % 4) == 0;
                if (sleep_left > 0) begin
                    sleep_left--;
                end else if (($urandom % 200) == 0) begin
                    sleep_left = 2 + ($urandom % 5);
                end
                sleep_req = (sleep_left > 0);
                tick();
            end
        end
        sleep_req = 1'b0;
        repeat (4) op_desel();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule